// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A 13-bit clock control word selects one of two division schemes. With the select bit set, the divider is linear: the serial clock is the module clock divided by 2·(N+1), where N is an 8-bit field. With the select bit clear, the divider is a power of two: the module clock is divided by 2^M, where M is a 4-bit field. Every division keeps the module clock at least twice as fast as the serial clock. The block therefore works from a half-period count. The linear mode counts N+1 module clocks per half period, which gives an even 50% duty cycle. The power-of-two mode counts 2^(M-1) module clocks per half period. M = 0 is clamped to one module clock per half period, so an edge tick is reported on every cycle.

The shift engine controls the block with one `run` level. While `run` is low, the serial clock rests at the level that the polarity input sets. The first cycle in which `run` is seen high latches the control word, the polarity and the phase, and the serial clock then toggles once per half period. Besides the registered clock level, the block gives one-cycle registered pulses for the leading and trailing edges of each serial clock period. It also gives the same edges mapped by the phase input onto sample and shift strobes, for the shift engine to use as clock enables.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `rst` is high, on each clock edge `sclk` takes the value of `cpol` and all four pulse outputs go low.
- R2: While `run` is low, on each clock edge `sclk` takes the value of `cpol` and all four pulse outputs go low.
- R3: When `clk_ctl[12]` = 1 (linear mode), the half period is N+1 module clocks, with N = `clk_ctl[7:0]`. Let k = 0 be the output cycle that follows the edge at which `run` is first seen high. Then `sclk` toggles in cycles k = h, 2h, 3h, …, where h is the half period.
- R4: When `clk_ctl[12]` = 0 (power-of-two mode) and M = `clk_ctl[11:8]` is 1 or more, the half period is 2^(M-1) module clocks, and `clk_ctl[7:0]` has no effect.
- R5: In power-of-two mode with M = 0, the half period is one module clock, so an edge pulse is present in every cycle from k = 1 onwards.
- R6: `lead_pulse` is high for exactly the cycles in which `sclk` has just moved away from the latched idle level. `trail_pulse` is high for exactly the cycles in which `sclk` has just returned to it. The two are never high together.
- R7: With the latched phase 0, `sample_pulse` equals `lead_pulse` and `shift_pulse` equals `trail_pulse`. With the latched phase 1, the mapping is swapped.
- R8: `clk_ctl`, `cpol` and `cpha` are latched only at the edge where `run` is first seen high. Changes to them during a transfer do not alter the serial clock or the pulses until the next transfer.
- R9: When `run` falls, `sclk` returns to `cpol` on the next edge, even in the middle of a period. A new transfer restarts the half-period count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transfer active level from the shift engine |
| clk_ctl | input | 13 | Clock control word: [7:0] linear N, [11:8] exponent M, [12] mode select (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Phase: 0 samples on the leading edge, 1 on the trailing edge |
| sclk | output | 1 | Registered serial clock level |
| lead_pulse | output | 1 | One-cycle pulse in the cycle the serial clock leaves its idle level |
| trail_pulse | output | 1 | One-cycle pulse in the cycle the serial clock returns to its idle level |
| sample_pulse | output | 1 | Sample strobe, the lead or trail pulse selected by the phase |
| shift_pulse | output | 1 | Shift strobe, the other of the two edge pulses |

## Verification
All outputs are registered. The start edge, at which `run` is first seen high, is taken as cycle 0, and the first toggle is due exactly h cycles later. The bench drives inputs five nanoseconds after a rising edge and samples all five outputs at that same offset after every following edge. It compares them with values computed from the cycle index k, the half period h and the polarity: `sclk` = `cpol` xor the parity of k/h, with a pulse whenever k > 0 and k mod h = 0. The idle level after `run` falls, or during reset, is due one edge after the change, and it is checked in that cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Division scheme encoded in the select bit of the clock control word
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  // Phase encoding of which edge carries the sample strobe
  typedef enum logic {
    SAMPLE_ON_LEAD  = 1'b0,
    SAMPLE_ON_TRAIL = 1'b1
  } phase_e;

  // Width needed to hold the largest half period of either scheme
  function automatic int half_width(input int lin_w, input int exp_w);
    int lin_need;
    int pow_need;
    lin_need = lin_w + 1;
    pow_need = (1 << exp_w) - 1;
    return (lin_need > pow_need) ? lin_need : pow_need;
  endfunction

endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch
  import sclk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = half_width(LIN_W, EXP_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   active,
  input  logic [LIN_W+EXP_W:0]   ctl,
  input  logic                   cpol,
  input  logic                   cpha,
  output logic [HALF_W-1:0]      half_q,
  output logic                   cpol_q,
  output phase_e                 cpha_q
);

  localparam int SEL_BIT = LIN_W + EXP_W;

  div_mode_e           mode;
  logic [LIN_W-1:0]    lin_n;
  logic [EXP_W-1:0]    pow_m;
  logic [HALF_W-1:0]   half_lin;
  logic [HALF_W-1:0]   half_pow;
  logic [HALF_W-1:0]   half_next;
  logic                start;

  assign start = run && !active;

  always_comb begin
    mode     = div_mode_e'(ctl[SEL_BIT]);
    lin_n    = ctl[LIN_W-1:0];
    pow_m    = ctl[SEL_BIT-1:LIN_W];
    half_lin = HALF_W'(lin_n) + HALF_W'(1);
    if (pow_m == '0) begin
      half_pow = HALF_W'(1);
    end else begin
      half_pow = HALF_W'(1) << (pow_m - EXP_W'(1));
    end
    half_next = (mode == DIV_LINEAR) ? half_lin : half_pow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_W'(1);
      cpol_q <= 1'b0;
      cpha_q <= SAMPLE_ON_LEAD;
    end else if (start) begin
      half_q <= half_next;
      cpol_q <= cpol;
      cpha_q <= phase_e'(cpha);
    end
  end

  // R8: settings do not move while a transfer keeps running
  p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && active) |-> ($stable(half_q) && $stable(cpol_q) && $stable(cpha_q)));

  // R3/R4/R5: a latched half period is never zero
  p_half_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    active |-> (half_q != '0));

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              active,
  output logic              toggle
);

  logic [HALF_W-1:0] cnt;
  logic              at_end;

  assign at_end = (cnt == (half - HALF_W'(1)));
  assign toggle = run && active && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  // R3: the count stays inside the latched half period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < half));

  // R9: a dropped run clears the timer on the next edge
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!active && cnt == '0));

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import sclk_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   active,
  input  logic   toggle,
  input  logic   cpol,
  input  logic   cpol_q,
  input  phase_e cpha_q,
  output logic   sclk,
  output logic   lead_pulse,
  output logic   trail_pulse,
  output logic   sample_pulse,
  output logic   shift_pulse
);

  logic leaving_idle;

  assign leaving_idle = (sclk == cpol_q);

  always_ff @(posedge clk) begin
    if (rst || !run || !active) begin
      sclk         <= cpol;
      lead_pulse   <= 1'b0;
      trail_pulse  <= 1'b0;
      sample_pulse <= 1'b0;
      shift_pulse  <= 1'b0;
    end else if (toggle) begin
      sclk         <= ~sclk;
      lead_pulse   <= leaving_idle;
      trail_pulse  <= !leaving_idle;
      sample_pulse <= (cpha_q == SAMPLE_ON_LEAD) ? leaving_idle : !leaving_idle;
      shift_pulse  <= (cpha_q == SAMPLE_ON_LEAD) ? !leaving_idle : leaving_idle;
    end else begin
      lead_pulse   <= 1'b0;
      trail_pulse  <= 1'b0;
      sample_pulse <= 1'b0;
      shift_pulse  <= 1'b0;
    end
  end

  // R2: idle holds the polarity level and no pulses
  p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol) && !lead_pulse && !trail_pulse));

  // R6: the edge pulses are exclusive and mark a real change of level
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_pulse, trail_pulse}));
  p_edge_moves_r6: assert property (@(posedge clk) disable iff (rst)
    (lead_pulse || trail_pulse) |-> (sclk != $past(sclk)));
  p_lead_away_r6: assert property (@(posedge clk) disable iff (rst)
    lead_pulse |-> (sclk != cpol_q));

  // R7: sample and shift are the two edges split by phase
  p_strobe_split_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_pulse, shift_pulse}) &&
    ((sample_pulse || shift_pulse) == (lead_pulse || trail_pulse)));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [LIN_W+EXP_W:0] clk_ctl,
  input  logic                 cpol,
  input  logic                 cpha,
  output logic                 sclk,
  output logic                 lead_pulse,
  output logic                 trail_pulse,
  output logic                 sample_pulse,
  output logic                 shift_pulse
);

  localparam int HALF_W = half_width(LIN_W, EXP_W);

  logic [HALF_W-1:0] half_q;
  logic              cpol_q;
  phase_e            cpha_q;
  logic              active;
  logic              toggle;

  sclk_cfg_latch #(
    .LIN_W  (LIN_W),
    .EXP_W  (EXP_W),
    .HALF_W (HALF_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .active (active),
    .ctl    (clk_ctl),
    .cpol   (cpol),
    .cpha   (cpha),
    .half_q (half_q),
    .cpol_q (cpol_q),
    .cpha_q (cpha_q)
  );

  sclk_half_timer #(
    .HALF_W (HALF_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .half   (half_q),
    .active (active),
    .toggle (toggle)
  );

  sclk_edge_gen u_edge (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .active       (active),
    .toggle       (toggle),
    .cpol         (cpol),
    .cpol_q       (cpol_q),
    .cpha_q       (cpha_q),
    .sclk         (sclk),
    .lead_pulse   (lead_pulse),
    .trail_pulse  (trail_pulse),
    .sample_pulse (sample_pulse),
    .shift_pulse  (shift_pulse)
  );

  // R1: reset leaves the clock at the polarity level with no pulses
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (sclk == $past(cpol) && !lead_pulse && !trail_pulse &&
                    !sample_pulse && !shift_pulse));

endmodule

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [12:0] clk_ctl = '0;
  logic        cpol = 1'b1;
  logic        cpha = 1'b0;
  logic        sclk, lead_pulse, trail_pulse, sample_pulse, shift_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_divider i_spi_sclk_divider (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .clk_ctl      (clk_ctl),
    .cpol         (cpol),
    .cpha         (cpha),
    .sclk         (sclk),
    .lead_pulse   (lead_pulse),
    .trail_pulse  (trail_pulse),
    .sample_pulse (sample_pulse),
    .shift_pulse  (shift_pulse)
  );

  // Vector table: control word, polarity, phase, expected half period
  localparam int NV = 8;
  localparam logic [12:0] V_CTL  [NV] = '{13'h1000, 13'h1002, 13'h10FF, 13'h0100,
                                          13'h0300, 13'h0000, 13'h0900, 13'h05AB};
  localparam logic        V_CPOL [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_CPHA [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int          V_HALF [NV] = '{1, 3, 256, 1, 4, 1, 256, 16};

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sclk,lead,trail,sample,shift} got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_at(int k, int h, logic pol, logic pha);
    int   t;
    logic edge_now, lead, trail;
    t        = k / h;
    edge_now = (k > 0) && (k % h == 0);
    lead     = edge_now && t[0];
    trail    = edge_now && !t[0];
    return {pol ^ t[0], lead, trail, pha ? trail : lead, pha ? lead : trail};
  endfunction

  function automatic logic [4:0] outs();
    return {sclk, lead_pulse, trail_pulse, sample_pulse, shift_pulse};
  endfunction

  // Called right after inputs are set at posedge+5; k = 0 is the next sample
  task automatic walk(input string tag, input int first_k, input int n,
                      input int h, input logic pol, input logic pha);
    for (int k = first_k; k < first_k + n; k++) begin
      @(posedge clk); #5;
      check(tag, outs(), expect_at(k, h, pol, pha));
    end
  endtask

  task automatic idle_check(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      check(tag, outs(), {cpol, 4'b0000});
    end
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state follows polarity
    repeat (2) @(posedge clk);
    #5;
    check("R1 reset cpol=1", outs(), 5'b10000);
    cpol = 1'b0;
    @(posedge clk); #5;
    check("R1 reset cpol=0", outs(), 5'b00000);
    rst = 1'b0;

    // R2: idle follows polarity
    cpol = 1'b1;
    idle_check("R2 idle", 3);

    // Table walk: R3 linear, R4 power of two, R5 M=0, R6/R7 pulses
    for (int v = 0; v < NV; v++) begin
      clk_ctl = V_CTL[v];
      cpol    = V_CPOL[v];
      cpha    = V_CPHA[v];
      idle_check("R2 idle before run", 2);
      run = 1'b1;
      walk($sformatf("R3/R4/R5/R6/R7 vector %0d", v), 0, 4 * V_HALF[v] + 2,
           V_HALF[v], V_CPOL[v], V_CPHA[v]);
      run = 1'b0;
      idle_check("R9 stop to idle", 1);
    end

    // R5: M=0 gives an edge pulse on every cycle
    clk_ctl = 13'h0000; cpol = 1'b0; cpha = 1'b0;
    idle_check("R2 idle", 1);
    run = 1'b1;
    @(posedge clk); #5;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #5;
      check("R5 pulse every cycle", {4'b0000, lead_pulse | trail_pulse}, 5'b00001);
    end
    run = 1'b0;
    idle_check("R9 stop", 1);

    // R8: changes during a transfer are ignored
    clk_ctl = 13'h1001; cpol = 1'b1; cpha = 1'b1;
    idle_check("R2 idle", 1);
    run = 1'b1;
    walk("R8 before change", 0, 2, 2, 1'b1, 1'b1);
    clk_ctl = 13'h1007; cpol = 1'b0; cpha = 1'b0;
    walk("R8 after change", 2, 9, 2, 1'b1, 1'b1);
    run = 1'b0;
    idle_check("R9 stop", 1);

    // R9: drop in mid-period, then restart counts from zero
    clk_ctl = 13'h1003; cpol = 1'b0; cpha = 1'b0;
    idle_check("R2 idle", 1);
    run = 1'b1;
    walk("R9 first run", 0, 6, 4, 1'b0, 1'b0);
    run = 1'b0;
    idle_check("R9 mid-period stop", 2);
    run = 1'b1;
    walk("R9 restart", 0, 10, 4, 1'b0, 1'b0);
    run = 1'b0;
    idle_check("R9 stop", 1);

    // R4: linear field ignored in power-of-two mode (M=2, N differs)
    clk_ctl = 13'h02FF; cpol = 1'b1; cpha = 1'b0;
    idle_check("R2 idle", 1);
    run = 1'b1;
    walk("R4 N ignored", 0, 9, 2, 1'b1, 1'b0);
    run = 1'b0;
    idle_check("R9 stop", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule